// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge sits between a CPU-side request bus and the single 32-bit port of an SRAM. It recognises two address windows. The band window is 1 MiB of ordinary word storage and is passed through unchanged. The alias window is 32 MiB, and every bit of the band window owns one 32-bit word in it. An access to an alias word acts on that single bit of the backing band word.

A store to an alias word becomes a read-modify-write. The bridge carries out the whole sequence by itself, and the CPU cannot start another access until the write has gone out. A load from an alias word returns the selected bit in bit 0. Any address outside both windows receives a one-cycle error response. The bridge keeps at most one access in flight at a time. Every accepted request yields exactly one response, and no two requests are ever merged.

Top module: `bitband_bridge`

## Requirements
- R1: While reset is held, and in the first cycle after it, `cpu_ready` is 1, and `rsp_valid` and `mem_en` are 0.
- R2: The band window is 0x2000_0000 to 0x200F_FFFF. A read in this window issues a memory read in the accept cycle with `mem_addr` = address bits 19:2. The full word comes back with `rsp_valid` one cycle after accept and with `rsp_err` = 0.
- R3: A write in the band window drives `mem_en`=1, `mem_we`=1 and `mem_wdata` = `cpu_wdata` in the accept cycle. It is acknowledged one cycle later with `rsp_err` = 0.
- R4: The alias window is 0x2200_0000 to 0x23FF_FFFF. In this window the backing word index is address bits 24:7 and the bit number is address bits 6:2, so the alias address is 0x2200_0000 + byte_offset×32 + bit×4. Address bits 1:0 have no effect.
- R5: An alias write reads the backing word in the accept cycle. In the next cycle it writes that word back with only the selected bit changed, set to `cpu_wdata[0]`. Write-data bits 31:1 have no effect. The acknowledge follows two cycles after accept.
- R6: From the accept cycle of an alias write until its write has been issued, `cpu_ready` stays 0. No memory access other than that write happens between the read and the write.
- R7: An alias read returns the selected bit in `rsp_rdata[0]` with bits 31:1 zero, one cycle after accept. It issues exactly one memory read and no memory write.
- R8: An address outside both windows produces `rsp_valid`=1 with `rsp_err`=1 one cycle after accept. It causes no memory access.
- R9: Every accepted request produces exactly one response. Back-to-back alias writes each perform their own read and their own write, with no coalescing.
- R10: `cpu_ready` is 0 in every cycle that carries a response. Only one access is ever outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Request valid; accepted when `cpu_ready` is 1 |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_ready | output | 1 | Bridge can accept a request this cycle |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_err | output | 1 | Response is an address error |
| rsp_rdata | output | 32 | Read data of the response |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 18 | Memory word index |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid one cycle after a read |

## Verification
The bench sets and clears bit 0 and bit 31 of the first and last band words through their alias addresses. A bridge that took the word index or bit number from the wrong address bits would corrupt a neighbouring bit or word, and band read-back exposes that. Alias stores are sent with random junk in write-data bits 31:1 and in address bits 1:0. A bridge that honoured either would set the wrong value or hit the wrong bit. The bench counts memory reads and writes per access and measures response latency. This catches merged or dropped alias writes, a write issued without a preceding read, an alias read that writes, an error access that reaches memory, and a bridge that reopens `cpu_ready` before the write-back. Addresses just outside each window edge check that the decoder bounds are exact.

// File: rtl/bb_pkg.sv
package bb_pkg;

    localparam int unsigned DATA_W     = 32;
    localparam int unsigned ADDR_W     = 32;
    localparam int unsigned WORD_IDX_W = 18;
    localparam int unsigned BIT_IDX_W  = $clog2(DATA_W);

    typedef enum logic [1:0] {
        REG_NONE  = 2'd0,
        REG_BAND  = 2'd1,
        REG_ALIAS = 2'd2
    } region_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ERR     = 3'd1,
        ST_ACK     = 3'd2,
        ST_PASS_RD = 3'd3,
        ST_BIT_RD  = 3'd4,
        ST_BIT_WR  = 3'd5
    } state_e;

    typedef struct packed {
        region_e                region;
        logic                   we;
        logic [WORD_IDX_W-1:0]  word;
        logic [BIT_IDX_W-1:0]   bitno;
        logic                   setval;
    } bb_op_t;

    function automatic logic window_hit(input logic [ADDR_W-1:0] addr,
                                        input logic [ADDR_W-1:0] base,
                                        input int unsigned       span_lsb);
        logic [ADDR_W-1:0] mask;
        mask = ~((ADDR_W'(1) << span_lsb) - ADDR_W'(1));
        return (addr & mask) == (base & mask);
    endfunction

endpackage

// File: rtl/bb_decode.sv
module bb_decode
    import bb_pkg::*;
#(
    parameter logic [ADDR_W-1:0] BAND_BASE  = 32'h2000_0000,
    parameter logic [ADDR_W-1:0] ALIAS_BASE = 32'h2200_0000
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output bb_op_t            op
);
    localparam int unsigned BAND_LSB  = WORD_IDX_W + 2;
    localparam int unsigned ALIAS_LSB = WORD_IDX_W + BIT_IDX_W + 2;

    logic band_hit;
    logic alias_hit;
    logic unused_bits;

    assign band_hit    = window_hit(addr, BAND_BASE, BAND_LSB);
    assign alias_hit   = window_hit(addr, ALIAS_BASE, ALIAS_LSB);
    assign unused_bits = ^{addr[1:0], wdata[DATA_W-1:1]};

    always_comb begin
        op.we     = we;
        op.setval = wdata[0];
        op.bitno  = addr[BIT_IDX_W+1:2];
        if (alias_hit) begin
            op.region = REG_ALIAS;
            op.word   = addr[ALIAS_LSB-1:BIT_IDX_W+2];
        end else if (band_hit) begin
            op.region = REG_BAND;
            op.word   = addr[BAND_LSB-1:2];
        end else begin
            op.region = REG_NONE;
            op.word   = addr[BAND_LSB-1:2];
        end
    end
endmodule

// File: rtl/bb_merge.sv
module bb_merge
    import bb_pkg::*;
(
    input  logic [DATA_W-1:0]    rd_word,
    input  logic [BIT_IDX_W-1:0] bitno,
    input  logic                 setval,
    output logic [DATA_W-1:0]    merged,
    output logic                 picked
);
    logic [DATA_W-1:0] sel;

    for (genvar i = 0; i < DATA_W; i++) begin : g_lane
        assign sel[i]    = (bitno == BIT_IDX_W'(i));
        assign merged[i] = sel[i] ? setval : rd_word[i];
    end

    assign picked = |(sel & rd_word);
endmodule

// File: rtl/bb_ctrl.sv
module bb_ctrl
    import bb_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cpu_req,
    input  logic [DATA_W-1:0]      cpu_wdata,
    input  bb_op_t                 op,
    input  logic [DATA_W-1:0]      mem_rdata,
    input  logic [DATA_W-1:0]      merged,
    input  logic                   picked,
    output bb_op_t                 held,
    output logic                   cpu_ready,
    output logic                   rsp_valid,
    output logic                   rsp_err,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic                   mem_en,
    output logic                   mem_we,
    output logic [WORD_IDX_W-1:0]  mem_addr,
    output logic [DATA_W-1:0]      mem_wdata
);
    state_e st, nxt;
    logic   accept;

    assign accept = (st == ST_IDLE) && cpu_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            held <= '0;
        end else begin
            st <= nxt;
            if (accept) held <= op;
        end
    end

    always_comb begin
        nxt       = st;
        cpu_ready = 1'b0;
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        rsp_rdata = '0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = op.word;
        mem_wdata = cpu_wdata;
        case (st)
            ST_IDLE: begin
                cpu_ready = 1'b1;
                if (cpu_req) begin
                    case (op.region)
                        REG_BAND: begin
                            mem_en = 1'b1;
                            mem_we = op.we;
                            nxt    = op.we ? ST_ACK : ST_PASS_RD;
                        end
                        REG_ALIAS: begin
                            mem_en = 1'b1;
                            nxt    = op.we ? ST_BIT_WR : ST_BIT_RD;
                        end
                        default: nxt = ST_ERR;
                    endcase
                end
            end
            ST_ERR: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b1;
                nxt       = ST_IDLE;
            end
            ST_ACK: begin
                rsp_valid = 1'b1;
                nxt       = ST_IDLE;
            end
            ST_PASS_RD: begin
                rsp_valid = 1'b1;
                rsp_rdata = mem_rdata;
                nxt       = ST_IDLE;
            end
            ST_BIT_RD: begin
                rsp_valid = 1'b1;
                rsp_rdata = {{(DATA_W-1){1'b0}}, picked};
                nxt       = ST_IDLE;
            end
            ST_BIT_WR: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = held.word;
                mem_wdata = merged;
                nxt       = ST_ACK;
            end
            default: nxt = ST_IDLE;
        endcase
    end
endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
    import bb_pkg::*;
#(
    parameter logic [31:0] BAND_BASE  = 32'h2000_0000,
    parameter logic [31:0] ALIAS_BASE = 32'h2200_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_req,
    input  logic        cpu_we,
    input  logic [31:0] cpu_addr,
    input  logic [31:0] cpu_wdata,
    output logic        cpu_ready,
    output logic        rsp_valid,
    output logic        rsp_err,
    output logic [31:0] rsp_rdata,
    output logic        mem_en,
    output logic        mem_we,
    output logic [17:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata
);
    bb_op_t            op;
    bb_op_t            held;
    logic [DATA_W-1:0] merged;
    logic              picked;

    bb_decode #(.BAND_BASE(BAND_BASE), .ALIAS_BASE(ALIAS_BASE)) u_decode (
        .addr  (cpu_addr),
        .we    (cpu_we),
        .wdata (cpu_wdata),
        .op    (op)
    );

    bb_merge u_merge (
        .rd_word (mem_rdata),
        .bitno   (held.bitno),
        .setval  (held.setval),
        .merged  (merged),
        .picked  (picked)
    );

    bb_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cpu_req   (cpu_req),
        .cpu_wdata (cpu_wdata),
        .op        (op),
        .mem_rdata (mem_rdata),
        .merged    (merged),
        .picked    (picked),
        .held      (held),
        .cpu_ready (cpu_ready),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );
endmodule

// File: rtl/bitband_bridge_chk.sv
module bitband_bridge_chk #(
    parameter logic [31:0] BAND_BASE  = 32'h2000_0000,
    parameter logic [31:0] ALIAS_BASE = 32'h2200_0000
) (
    input logic        clk,
    input logic        rst,
    input logic        cpu_req,
    input logic        cpu_we,
    input logic [31:0] cpu_addr,
    input logic        cpu_ready,
    input logic        rsp_valid,
    input logic        rsp_err,
    input logic [31:0] rsp_rdata,
    input logic        mem_en,
    input logic        mem_we,
    input logic [17:0] mem_addr,
    input logic [31:0] mem_wdata,
    input logic [31:0] mem_rdata
);
    logic acc, in_alias, in_band, in_none;

    assign acc      = cpu_req && cpu_ready;
    assign in_alias = (cpu_addr[31:25] == ALIAS_BASE[31:25]);
    assign in_band  = (cpu_addr[31:20] == BAND_BASE[31:20]);
    assign in_none  = !in_alias && !in_band;

    AST_ALIAS_WR_READS_FIRST: assert property (@(posedge clk) disable iff (rst)
        acc && in_alias && cpu_we |-> mem_en && !mem_we && mem_addr == cpu_addr[24:7]); // R5
    AST_ALIAS_WR_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        acc && in_alias && cpu_we |=> $countones(mem_wdata ^ mem_rdata) <= 1); // R5
    AST_ALIAS_WR_LOCKED: assert property (@(posedge clk) disable iff (rst)
        acc && in_alias && cpu_we |=> mem_en && mem_we && !cpu_ready
                                      && mem_addr == $past(cpu_addr[24:7])); // R6
    AST_ALIAS_RD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        acc && in_alias && !cpu_we |=> !mem_en && rsp_valid && rsp_rdata[31:1] == 31'd0); // R7
    AST_ERR_NO_MEM: assert property (@(posedge clk) disable iff (rst)
        acc && in_none |-> !mem_en); // R8
    AST_ERR_RESPONSE: assert property (@(posedge clk) disable iff (rst)
        acc && in_none |=> rsp_valid && rsp_err); // R8
    AST_RSP_BLOCKS_READY: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !cpu_ready); // R10
    AST_BAND_WR_PASS: assert property (@(posedge clk) disable iff (rst)
        acc && in_band && cpu_we |-> mem_en && mem_we && mem_addr == cpu_addr[19:2]); // R3
endmodule

bind bitband_bridge bitband_bridge_chk #(.BAND_BASE(BAND_BASE), .ALIAS_BASE(ALIAS_BASE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cpu_req   (cpu_req),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_ready (cpu_ready),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
);

// File: tb/tb_bitband_bridge.sv
module tb_bitband_bridge;
    logic        clk = 1'b0;
    logic        rst;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_ready, rsp_valid, rsp_err, mem_en, mem_we;
    logic [31:0] rsp_rdata, mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [17:0] mem_addr;

    int checks = 0, errors = 0, n_rd = 0, n_wr = 0;
    logic [31:0] sram [logic [17:0]];
    logic [31:0] refm [logic [17:0]];

    always #4 clk = ~clk;

    bitband_bridge dut (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] seed_word(logic [17:0] i);
        return {i[13:0], i} ^ 32'hA5C3_1E69;
    endfunction

    function automatic logic [31:0] ref_get(logic [17:0] i);
        return refm.exists(i) ? refm[i] : seed_word(i);
    endfunction

    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) begin
                sram[mem_addr] = mem_wdata;
                n_wr++;
            end else begin
                mem_rdata <= sram.exists(mem_addr) ? sram[mem_addr] : seed_word(mem_addr);
                n_rd++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [31:0] addr, input logic [31:0] wd,
                          output logic [31:0] rd, output logic er, output int lat,
                          output int nr, output int nw, output bit busy_ok);
        int r0, w0;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        while (!cpu_ready) @(negedge clk);
        r0 = n_rd; w0 = n_wr;
        @(negedge clk);
        cpu_req = 1'b0; cpu_wdata = $urandom; cpu_addr = $urandom;
        lat = 1; busy_ok = 1;
        while (!rsp_valid && lat < 8) begin
            if (cpu_ready) busy_ok = 0;
            @(negedge clk);
            lat++;
        end
        if (cpu_ready) busy_ok = 0;
        rd = rsp_rdata; er = rsp_err;
        @(negedge clk);
        nr = n_rd - r0; nw = n_wr - w0;
    endtask

    // kind: 0 band read, 1 band write, 2 alias read, 3 alias write, 4 out of window
    task automatic run_op(input int kind, input logic [17:0] idx, input logic [4:0] b,
                          input logic [31:0] wd, input logic [1:0] lo, input logic [31:0] bad_addr);
        logic [31:0] rd, exp, aaddr, baddr;
        logic er;
        int lat, nr, nw;
        bit busy_ok;
        aaddr = 32'h2200_0000 + {7'd0, idx, b, lo};
        baddr = 32'h2000_0000 + {12'd0, idx, lo};
        case (kind)
            0: begin
                access(1'b0, baddr, wd, rd, er, lat, nr, nw, busy_ok);
                exp = ref_get(idx);
                chk(rd == exp && !er, "R2 band read data", rd, exp);
                chk(lat == 1 && nr == 1 && nw == 0, "R2 band read timing/mem ops", lat, 1);
            end
            1: begin
                access(1'b1, baddr, wd, rd, er, lat, nr, nw, busy_ok);
                refm[idx] = wd;
                chk(!er && lat == 1 && nr == 0 && nw == 1, "R3 band write ack/mem ops", lat, 1);
                chk(sram[idx] == wd, "R3 band write data", sram[idx], wd);
            end
            2: begin
                access(1'b0, aaddr, wd, rd, er, lat, nr, nw, busy_ok);
                exp = {31'd0, ref_get(idx)[b]};
                chk(rd == exp && !er, "R7 R4 alias read bit", rd, exp);
                chk(lat == 1 && nr == 1 && nw == 0, "R7 alias read mem ops", nw, 0);
            end
            3: begin
                access(1'b1, aaddr, wd, rd, er, lat, nr, nw, busy_ok);
                exp = ref_get(idx);
                exp[b] = wd[0];
                refm[idx] = exp;
                chk(sram.exists(idx) && sram[idx] == exp, "R5 R4 alias write merged word",
                    sram.exists(idx) ? sram[idx] : 32'hx, exp);
                chk(!er && lat == 2, "R5 alias write ack latency", lat, 2);
                chk(nr == 1 && nw == 1, "R9 alias write own read+write", nw, 1);
                chk(busy_ok, "R6 ready low during read-modify-write", busy_ok, 1);
            end
            default: begin
                access(wd[0], bad_addr, wd, rd, er, lat, nr, nw, busy_ok);
                chk(er && lat == 1, "R8 error response", er, 1);
                chk(nr == 0 && nw == 0, "R8 no memory access", nr + nw, 0);
            end
        endcase
        if (kind != 3) chk(busy_ok, "R10 ready low while response pending", busy_ok, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] bad [6];
        void'($urandom(32'd2024));
        bad[0] = 32'h2010_0000; bad[1] = 32'h21FF_FFFC; bad[2] = 32'h2400_0000;
        bad[3] = 32'h1FFF_FFFC; bad[4] = 32'h0000_0000; bad[5] = 32'hE000_E000;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(cpu_ready && !rsp_valid && !mem_en, "R1 state in reset",
            {29'd0, cpu_ready, rsp_valid, mem_en}, 32'd4);
        rst = 1'b0;
        @(negedge clk);
        chk(cpu_ready && !rsp_valid && !mem_en, "R1 state after reset",
            {29'd0, cpu_ready, rsp_valid, mem_en}, 32'd4);

        // directed corners: first/last word, bit 0/31, junk in wdata and low address bits
        run_op(1, 18'd0, 5'd0, 32'h0000_0000, 2'd0, 0);
        run_op(3, 18'd0, 5'd0, 32'hFFFF_FFFF, 2'd3, 0);
        run_op(3, 18'd0, 5'd31, 32'h0000_0001, 2'd1, 0);
        run_op(0, 18'd0, 5'd0, 32'd0, 2'd0, 0);
        run_op(3, 18'h3FFFF, 5'd31, 32'hFFFF_FFFE, 2'd2, 0);
        run_op(2, 18'h3FFFF, 5'd31, 32'd0, 2'd3, 0);
        run_op(3, 18'h3FFFF, 5'd0, 32'h8000_0001, 2'd0, 0);
        run_op(0, 18'h3FFFF, 5'd0, 32'd0, 2'd0, 0);
        // back-to-back alias writes to the same word (R9)
        run_op(3, 18'd5, 5'd3, 32'd1, 2'd0, 0);
        run_op(3, 18'd5, 5'd4, 32'd1, 2'd0, 0);
        run_op(3, 18'd5, 5'd3, 32'd0, 2'd0, 0);
        run_op(0, 18'd5, 5'd0, 32'd0, 2'd0, 0);
        for (int i = 0; i < 6; i++) run_op(4, 18'd0, 5'd0, 32'd0, 2'd0, bad[i]);

        for (int n = 0; n < 600; n++) begin
            logic [17:0] idx;
            idx = ($urandom % 4 == 0) ? (18'h3FFC0 + 18'($urandom % 64)) : 18'($urandom % 64);
            run_op(int'($urandom % 5), idx, 5'($urandom), $urandom, 2'($urandom),
                   bad[$urandom % 6]);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule